// File: doc/BRIEF.md
# Multidrop Receive Address Filter

This block sits between a UART character deserializer and the consumer of received bytes on a multidrop serial network. Each incoming character arrives with a flag bit that marks it as an address byte (flag 1) or a data byte (flag 0). In the hardware-match mode, the filter compares each address byte with a node address supplied by software. Data bytes are forwarded only while the most recent address byte matched. Address bytes are absorbed silently and never reach the consumer. The first data byte forwarded after each matching address carries a frame-start tag, so software can see frame boundaries without handling an interrupt per address.

In the other modes the filter is transparent. Every character, address or data, is forwarded untagged and raises an interrupt pulse. Both the input and the output are valid/ready streams with a single output register.

Back-pressure rules:
- Input: `rx_ready` is high whenever the output register is empty or is being drained in the same cycle. A character is taken on any edge where `rx_valid` and `rx_ready` are both high, including characters that are then dropped.
- Output: the beat on the output is held until `out_ready` is sampled high.

Top module: `mpf_addr_filter`

## Requirements
- R1: After reset `out_valid`, `out_first` and `irq` are 0, `rx_ready` is 1, and the filter is in the unmatched state.
- R2: `rx_ready` equals `!out_valid || out_ready`. A character that is taken and forwarded appears on `out_data`, with `out_valid` high, on the cycle after the taking edge.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_first` remain unchanged.
- R4: When `mode` is 2'b00, 2'b01 or 2'b10, every taken character is forwarded regardless of its flag, with `out_first` 0. `irq` pulses high for exactly one cycle on the cycle its beat appears.
- R5: When `mode` is 2'b11, a taken address byte (`rx_addr_flag` 1) produces no output beat and no `irq` pulse. Its value is compared with `node_addr` to set the matched state.
- R6: When `mode` is 2'b11, the first data byte taken after a matching address byte is forwarded with `out_first` 1 and an `irq` pulse.
- R7: When `mode` is 2'b11, later data bytes after a matching address, up to the next address byte, are forwarded with `out_first` 0.
- R8: When `mode` is 2'b11, after a non-matching address byte all data bytes are taken and discarded with no output and no `irq`, until the next address byte.
- R9: Out of reset, data bytes in mode 2'b11 are discarded until a matching address byte is seen.
- R10: The matched state and the pending frame-start tag change only on characters taken in mode 2'b11. Characters taken in the transparent modes leave them untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Filter mode: 2'b11 hardware match, other values transparent |
| node_addr | input | DATA_W | Address compared against incoming address bytes |
| rx_valid | input | 1 | Received character valid |
| rx_ready | output | 1 | Filter can take a character |
| rx_data | input | DATA_W | Received character |
| rx_addr_flag | input | 1 | 1 = address byte, 0 = data byte |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | DATA_W | Forwarded data byte |
| out_first | output | 1 | Beat is the first data byte of a frame |
| irq | output | 1 | One-cycle pulse for each forwarded beat |

## Verification
Two events can fall in the same cycle: the consumer draining the output register, and a new character being taken (forwarded, absorbed as an address, or dropped). The bench provokes this by holding `rx_valid` high across a throttled `out_ready` pattern, so takes land exactly on drain edges as well as after stalls. It judges the result by popping every drained beat from a scoreboard built by an independent frame model, with the frame-start tag included. On every cycle it checks that `rx_ready` tracks the drain and that a stalled beat holds steady. An absorbed address or a dropped data byte taken on a drain edge must leave neither a stray beat nor an extra `irq` pulse.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  localparam int unsigned MPF_MODE_W = 2;

  typedef enum logic [MPF_MODE_W-1:0] {
    MPF_TRANSPARENT   = 2'b00,
    MPF_TRANSPARENT_B = 2'b01,
    MPF_TRANSPARENT_C = 2'b10,
    MPF_HW_MATCH      = 2'b11
  } mpf_mode_e;

  function automatic logic mpf_filtering(input logic [MPF_MODE_W-1:0] m);
    return mpf_mode_e'(m) == MPF_HW_MATCH;
  endfunction
endpackage

// File: rtl/mpf_classify.sv
module mpf_classify
  import mpf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [MPF_MODE_W-1:0] mode,
  input  logic                  addr_flag,
  input  logic [DATA_W-1:0]     data,
  input  logic [DATA_W-1:0]     node_addr,
  output logic                  filt,
  output logic                  addr_ev,
  output logic                  data_ev,
  output logic                  hit
);
  logic [DATA_W-1:0] bit_eq;

  for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
    assign bit_eq[i] = ~(data[i] ^ node_addr[i]);
  end

  always_comb begin
    filt    = mpf_filtering(mode);
    addr_ev = filt && addr_flag;
    data_ev = filt && !addr_flag;
    hit     = &bit_eq;
  end
endmodule

// File: rtl/mpf_frame_track.sv
module mpf_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic addr_ev,
  input  logic data_ev,
  input  logic hit,
  output logic pass,
  output logic first_tag
);
  logic matched_q, first_pend_q;

  assign pass      = data_ev && matched_q;
  assign first_tag = first_pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      matched_q    <= 1'b0;
      first_pend_q <= 1'b0;
    end else if (take && addr_ev) begin
      matched_q    <= hit;
      first_pend_q <= hit;
    end else if (take && pass) begin
      first_pend_q <= 1'b0;
    end
  end

  p_hit_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && addr_ev && hit |=> matched_q && first_pend_q);
  p_miss_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && addr_ev && !hit |=> !matched_q && !first_pend_q);
  p_tag_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && pass |=> !first_pend_q);
  p_state_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && (addr_ev || data_ev)) |=> $stable(matched_q) && $stable(first_pend_q));
endmodule

// File: rtl/mpf_out_stage.sv
module mpf_out_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_first,
  output logic              can_take,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_first,
  output logic              irq
);
  logic              vld_q, first_q, irq_q;
  logic [DATA_W-1:0] data_q;

  assign can_take  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_first = first_q;
  assign irq       = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      first_q <= 1'b0;
      irq_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      irq_q <= load;
      if (load) begin
        vld_q   <= 1'b1;
        data_q  <= in_data;
        first_q <= in_first;
      end else if (out_ready) begin
        vld_q   <= 1'b0;
        first_q <= 1'b0;
      end
    end
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_first));
  p_irq_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> out_valid);
  p_no_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> can_take);
endmodule

// File: rtl/mpf_addr_filter.sv
module mpf_addr_filter
  import mpf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MPF_MODE_W-1:0] mode,
  input  logic [DATA_W-1:0]     node_addr,
  input  logic                  rx_valid,
  output logic                  rx_ready,
  input  logic [DATA_W-1:0]     rx_data,
  input  logic                  rx_addr_flag,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DATA_W-1:0]     out_data,
  output logic                  out_first,
  output logic                  irq
);
  logic filt, addr_ev, data_ev, hit;
  logic take, pass, first_tag, load, can_take;

  mpf_classify #(.DATA_W(DATA_W)) u_classify (
    .mode(mode), .addr_flag(rx_addr_flag), .data(rx_data), .node_addr(node_addr),
    .filt(filt), .addr_ev(addr_ev), .data_ev(data_ev), .hit(hit)
  );

  mpf_frame_track u_track (
    .clk(clk), .rst_n(rst_n), .take(take), .addr_ev(addr_ev), .data_ev(data_ev),
    .hit(hit), .pass(pass), .first_tag(first_tag)
  );

  mpf_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .in_data(rx_data),
    .in_first(filt && first_tag), .can_take(can_take),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .irq(irq)
  );

  assign rx_ready = can_take;
  assign take     = rx_valid && rx_ready;
  assign load     = take && (!filt || pass);

  p_addr_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && mode == 2'b11 && rx_addr_flag |=> !irq);
  p_transparent_untagged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && mode != 2'b11 |=> out_valid && irq && !out_first);
  p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && !load |=> !irq);
endmodule

// File: tb/mpf_addr_filter_tb_top.sv
module mpf_addr_filter_tb_top;
  typedef struct {
    logic [7:0] data;
    logic       first;
    string      req;
  } beat_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b11;
  logic [7:0] node_addr = 8'h5A;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_addr_flag = 1'b0;
  logic       out_ready = 1'b1;
  logic       rx_ready, out_valid, out_first, irq;
  logic [7:0] out_data;

  int    n_vec = 0, n_bad = 0, n_irq = 0, n_push = 0, cyc = 0;
  int    rdy_style = 0;
  beat_t sb[$];
  logic  m_matched = 1'b0, m_first = 1'b0;

  always #10 clk = ~clk;

  mpf_addr_filter #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .node_addr(node_addr),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_addr_flag(rx_addr_flag), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_first(out_first), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Consumer throttle: changes at posedge + 2
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    case (rdy_style)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = (cyc % 5) > 2;
    endcase
  end

  // Monitor: samples at posedge + 8
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic       prev_first = 1'b0;
  always @(posedge clk) begin
    #8;
    if (rst_n) begin
      check(rx_ready == (!out_valid || out_ready), "R2", "rx_ready",
            rx_ready, !out_valid || out_ready);
      if (prev_stall)
        check(out_valid && out_data == prev_data && out_first == prev_first,
              "R3", "held beat", out_data, prev_data);
      if (irq) n_irq++;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8", "unexpected beat", out_data, 0);
        end else begin
          beat_t e;
          e = sb.pop_front();
          check(out_data == e.data, e.req, "data", out_data, e.data);
          check(out_first == e.first, e.req, "out_first", out_first, e.first);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_first = out_first;
    end
  end

  // Driver: entered at posedge + 2, returns at posedge + 2
  task automatic send(input logic [7:0] d, input logic a, input string req);
    bit ok;
    rx_valid = 1'b1; rx_data = d; rx_addr_flag = a;
    forever begin
      #6;
      ok = rx_ready;
      @(posedge clk); #2;
      if (ok) break;
    end
    rx_valid = 1'b0;
    if (mode != 2'b11) begin
      sb.push_back('{d, 1'b0, "R4"}); n_push++;
    end else if (a) begin
      m_matched = (d == node_addr);
      m_first   = m_matched;
    end else if (m_matched) begin
      sb.push_back('{d, m_first, m_first ? "R6" : "R7"}); n_push++;
      m_first = 1'b0;
    end
  endtask

  task automatic drain_idle(input string req);
    int guard = 0;
    while ((sb.size() != 0 || out_valid) && guard < 200) begin
      @(posedge clk); #2; guard++;
    end
    repeat (3) @(posedge clk);
    #2;
    check(!out_valid && sb.size() == 0, req, "idle/no stray beat", out_valid, 0);
    check(n_irq == n_push, req, "irq count", n_irq, n_push);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(!out_valid && !irq && !out_first && rx_ready, "R1", "reset outputs",
          {out_valid, irq, out_first, rx_ready}, 4'b0001);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R9: unmatched from reset
    send(8'h11, 1'b0, "R9");
    drain_idle("R9");
    // R5 / R8: miss then data dropped
    send(8'h33, 1'b1, "R5");
    send(8'h22, 1'b0, "R8");
    drain_idle("R8");
    // R6 / R7: hit then frame
    send(8'h5A, 1'b1, "R5");
    drain_idle("R5");
    send(8'h01, 1'b0, "R6");
    send(8'h02, 1'b0, "R7");
    send(8'h03, 1'b0, "R7");
    send(8'h5A, 1'b1, "R6");
    send(8'h10, 1'b1, "R8");
    send(8'h04, 1'b0, "R8");
    send(8'h5A, 1'b1, "R6");
    send(8'h05, 1'b0, "R6");
    drain_idle("R6");
    // R4: transparent modes
    mode = 2'b00;
    send(8'h06, 1'b0, "R4");
    send(8'hA5, 1'b1, "R4");
    mode = 2'b01;
    send(8'h07, 1'b1, "R4");
    mode = 2'b10;
    send(8'h0E, 1'b0, "R4");
    drain_idle("R4");
    // R10: matched state survives transparent traffic, tag already spent
    mode = 2'b11;
    send(8'h08, 1'b0, "R10");
    drain_idle("R10");
    // Stress with back-pressure and a new node address
    node_addr = 8'hC3;
    for (int s = 1; s <= 2; s++) begin
      rdy_style = s;
      for (int i = 0; i < 40; i++) begin
        if (i % 5 == 0)
          send(((i / 5) % 2 == 0) ? 8'hC3 : 8'h3C, 1'b1, "R5");
        else
          send(8'(i * 7 + s), 1'b0, "R7");
      end
      drain_idle("R3");
    end
    rdy_style = 0;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule